// File: doc/BRIEF.md
# Packed Dual Saturating Absolute-Value Unit

This block is a pipelined functional unit for a wide-issue datapath. Each issue carries a 32-bit source word made of two signed 16-bit lanes. The unit returns, for each lane on its own, the magnitude of that lane clipped to the positive signed range. The most negative lane value saturates to the largest positive value instead of wrapping. Results never cross from one lane into the other.

Writeback is predicated. An issue may carry a guard, and when it does, only the guard's least significant bit decides whether the destination is written. An issue without a guard always writes. The destination tag and the predicate travel down the pipeline with the data, so the result word, the write-enable and the tag all appear together a fixed two clock edges after issue.

The issue side is a plain valid strobe with no ready signal. The unit accepts one issue on every cycle and never exerts back-pressure, so a producer may issue on every cycle without waiting. The first source operand must be zero. A nonzero value there raises a flag that is aligned with the result; the flag has no effect on the result.

Top module: `dual_sat_abs`

## Requirements
- R1: The low lane of the result (bits 15:0) is the absolute value of source bits 15:0, read as a signed 16-bit integer.
- R2: The high lane of the result (bits 31:16) is derived only from source bits 31:16, using the same rule as R1. A value in one lane never changes the other lane.
- R3: A lane input of 0x8000 produces 0x7FFF. Bit 15 and bit 31 of every result are 0.
- R4: A non-negative lane passes through unchanged. A negative lane other than 0x8000 is replaced by its two's-complement negation. For example, 0xFFFF becomes 0x0001.
- R5: An issue sampled at clock edge k produces its result, write-enable and destination tag after edge k+1 and not before.
- R6: When `iss_guarded` is 1, `res_wen` is asserted for that issue only if `iss_guard_lsb` is 1.
- R7: When `iss_guarded` is 0, the issue always writes, whatever the value of `iss_guard_lsb`.
- R8: Issues presented on consecutive cycles each produce their own correct result, two cycles later, in issue order.
- R9: A synchronous active-high reset clears all pipeline valid state. `res_wen` is 0 on the cycle after any cycle in which reset was sampled, and issues in flight are dropped.
- R10: `res_a_nonzero` is 1, aligned with the result, exactly when the first operand of a valid issue was nonzero. It does not change `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe, accepted every cycle |
| iss_src_a | input | 32 | First operand, must be zero |
| iss_src_b | input | 32 | Packed source: two signed 16-bit lanes |
| iss_guarded | input | 1 | 1 when the issue carries a guard |
| iss_guard_lsb | input | 1 | Least significant bit of the guard word |
| iss_tag | input | TAG_W (7) | Destination register tag |
| res_data | output | 32 | Packed clipped absolute values |
| res_wen | output | 1 | Destination write-enable |
| res_tag | output | TAG_W (7) | Destination tag, aligned with the result |
| res_a_nonzero | output | 1 | First operand of this result was nonzero |

## Verification
The hardest case to reach from the ports is a predicated-off issue sitting between two writing issues in a back-to-back stream. The pipeline must drop the write for that one slot while its neighbours, one cycle apart, still write with their own tags and data. The stream test issues on every cycle and mixes guarded-false, guarded-true and unguarded issues with saturating lane values. Every output is compared with a model that is delayed by two cycles. A separate scenario raises reset while an issue is half way through the pipeline, and confirms that no write emerges.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int unsigned DEF_LANE_W = 16;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_TAG_W  = 7;

  // Control sideband carried through the first pipeline stage.
  typedef struct packed {
    logic valid;  // issue present
    logic wr_ok;  // predicate allows writeback
    logic a_nz;   // first operand was nonzero
  } dsa_ctl_t;
endpackage

// File: rtl/dsa_stage.sv
// Generic pipeline register with synchronous clear.
module dsa_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dsa_abs_lane.sv
// Saturating absolute value of one signed lane.
module dsa_abs_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] negated;

  always_comb begin
    negated = (~x) + 1'b1;
    if (x == MOST_NEG)   y = MOST_POS;
    else if (x[W-1])     y = negated;
    else                 y = x;
  end
endmodule

// File: rtl/dual_sat_abs.sv
module dual_sat_abs
  import dsa_pkg::*;
#(
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned TAG_W  = DEF_TAG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     iss_valid,
  input  logic [LANE_W*LANES-1:0]  iss_src_a,
  input  logic [LANE_W*LANES-1:0]  iss_src_b,
  input  logic                     iss_guarded,
  input  logic                     iss_guard_lsb,
  input  logic [TAG_W-1:0]         iss_tag,
  output logic [LANE_W*LANES-1:0]  res_data,
  output logic                     res_wen,
  output logic [TAG_W-1:0]         res_tag,
  output logic                     res_a_nonzero
);
  localparam int unsigned DW  = LANE_W * LANES;
  localparam int unsigned CW  = $bits(dsa_ctl_t);
  localparam int unsigned S1W = CW + TAG_W + DW;
  localparam int unsigned S2W = 2 + TAG_W + DW;

  // ---------------- stage 1: capture the issue ----------------
  dsa_ctl_t         ctl_in, ctl_s1;
  logic [TAG_W-1:0] tag_s1;
  logic [DW-1:0]    src_s1;
  logic [S1W-1:0]   s1_d, s1_q;

  always_comb begin
    ctl_in.valid = iss_valid;
    ctl_in.wr_ok = ~iss_guarded | iss_guard_lsb;  // unguarded acts as guard=1
    ctl_in.a_nz  = |iss_src_a;
    s1_d = {ctl_in, iss_tag, iss_src_b};
  end

  dsa_stage #(.W(S1W)) u_stage1 (
    .clk (clk),
    .rst (rst),
    .d   (s1_d),
    .q   (s1_q)
  );

  assign {ctl_s1, tag_s1, src_s1} = s1_q;

  // ---------------- lane datapath ----------------
  logic [DW-1:0] lane_res;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsa_abs_lane #(.W(LANE_W)) u_lane (
      .x (src_s1[g*LANE_W +: LANE_W]),
      .y (lane_res[g*LANE_W +: LANE_W])
    );
  end

  // ---------------- stage 2: result ----------------
  logic [S2W-1:0] s2_d, s2_q;

  assign s2_d = {ctl_s1.valid & ctl_s1.wr_ok,
                 ctl_s1.valid & ctl_s1.a_nz,
                 tag_s1, lane_res};

  dsa_stage #(.W(S2W)) u_stage2 (
    .clk (clk),
    .rst (rst),
    .d   (s2_d),
    .q   (s2_q)
  );

  assign {res_wen, res_a_nonzero, res_tag, res_data} = s2_q;
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned TAG_W  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iss_valid,
  input logic [LANE_W*LANES-1:0] iss_src_a,
  input logic [LANE_W*LANES-1:0] iss_src_b,
  input logic                    iss_guarded,
  input logic                    iss_guard_lsb,
  input logic [TAG_W-1:0]        iss_tag,
  input logic [LANE_W*LANES-1:0] res_data,
  input logic                    res_wen,
  input logic [TAG_W-1:0]        res_tag,
  input logic                    res_a_nonzero
);
  localparam int unsigned DW = LANE_W * LANES;

  function automatic logic [DW-1:0] ref_word(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    logic [LANE_W-1:0] v;
    r = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      v = w[i*LANE_W +: LANE_W];
      if (v == {1'b1, {(LANE_W-1){1'b0}}}) v = {1'b0, {(LANE_W-1){1'b1}}};
      else if (v[LANE_W-1])                v = -v;
      r[i*LANE_W +: LANE_W] = v;
    end
    return r;
  endfunction

  // R1 R2 R4: lane values follow the issued source
  a_r1_lane_values: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> res_data == ref_word($past(iss_src_b, 2)));

  // R3: sign bits of each lane result are clear
  a_r3_no_sign: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> (res_data[LANE_W-1] == 1'b0 && res_data[DW-1] == 1'b0));

  // R5: a write only follows an issue two edges earlier, with its tag
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> $past(iss_valid, 2));
  a_r5_tag: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> res_tag == $past(iss_tag, 2));

  // R6 R7: predication
  a_r6_guard: assert property (@(posedge clk) disable iff (rst)
    res_wen |-> ($past(~iss_guarded | iss_guard_lsb, 2)));

  // R9: reset clears the write path
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !res_wen);

  // R10: nonzero-first-operand flag is traced back to the issue
  a_r10_flag: assert property (@(posedge clk) disable iff (rst)
    res_a_nonzero |-> ($past(iss_src_a, 2) != '0 && $past(iss_valid, 2)));
endmodule

bind dual_sat_abs dsa_checker #(
  .LANE_W (LANE_W),
  .LANES  (LANES),
  .TAG_W  (TAG_W)
) u_dsa_checker (
  .clk           (clk),
  .rst           (rst),
  .iss_valid     (iss_valid),
  .iss_src_a     (iss_src_a),
  .iss_src_b     (iss_src_b),
  .iss_guarded   (iss_guarded),
  .iss_guard_lsb (iss_guard_lsb),
  .iss_tag       (iss_tag),
  .res_data      (res_data),
  .res_wen       (res_wen),
  .res_tag       (res_tag),
  .res_a_nonzero (res_a_nonzero)
);

// File: tb/dual_sat_abs_test.sv
module dual_sat_abs_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [31:0] iss_src_a;
  logic [31:0] iss_src_b;
  logic        iss_guarded;
  logic        iss_guard_lsb;
  logic [6:0]  iss_tag;
  logic [31:0] res_data;
  logic        res_wen;
  logic [6:0]  res_tag;
  logic        res_a_nonzero;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  dual_sat_abs uut (
    .clk (clk), .rst (rst), .iss_valid (iss_valid),
    .iss_src_a (iss_src_a), .iss_src_b (iss_src_b),
    .iss_guarded (iss_guarded), .iss_guard_lsb (iss_guard_lsb),
    .iss_tag (iss_tag), .res_data (res_data), .res_wen (res_wen),
    .res_tag (res_tag), .res_a_nonzero (res_a_nonzero)
  );

  function automatic logic [15:0] lane_ref(input logic [15:0] v);
    if (v == 16'h8000) return 16'h7fff;
    if (v[15])         return 16'h0000 - v;
    return v;
  endfunction

  function automatic logic [31:0] word_ref(input logic [31:0] w);
    return {lane_ref(w[31:16]), lane_ref(w[15:0])};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 0; iss_src_a = 0; iss_src_b = 0;
    iss_guarded = 0; iss_guard_lsb = 0; iss_tag = 0;
  endtask

  // Issue one operation at the current negedge and return after its result shows.
  task automatic issue_one(input logic [31:0] a, input logic [31:0] b,
                           input logic g, input logic gl, input logic [6:0] t);
    iss_valid = 1; iss_src_a = a; iss_src_b = b;
    iss_guarded = g; iss_guard_lsb = gl; iss_tag = t;
    step();
    idle();
    step();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    step(); step();
    check("R9 wen in reset", {31'd0, res_wen}, 32'd0);
    rst = 0;
    step();
    check("R9 wen after reset", {31'd0, res_wen}, 32'd0);
  endtask

  task automatic t_examples();
    issue_one(0, 32'hffff0032, 0, 0, 7'd6);
    check("R4 low pos / high neg", res_data, 32'h00010032);
    check("R5 tag", {25'd0, res_tag}, 32'd6);
    check("R7 unguarded writes", {31'd0, res_wen}, 32'd1);
    issue_one(0, 32'h80008001, 0, 0, 7'd10);
    check("R3 saturate high lane", res_data, 32'h7fff7fff);
    issue_one(0, 32'h0032ffff, 0, 0, 7'd8);
    check("R1 low lane negate", res_data, 32'h00320001);
    issue_one(0, 32'h7fffffff, 0, 0, 7'd11);
    check("R2 lanes independent", res_data, 32'h7fff0001);
    issue_one(0, 32'h80000000, 0, 0, 7'd12);
    check("R2 no cross lane", res_data, 32'h7fff0000);
  endtask

  task automatic t_guard();
    issue_one(0, 32'h80008001, 1, 0, 7'd7);
    check("R6 guard false no write", {31'd0, res_wen}, 32'd0);
    issue_one(0, 32'h80008001, 1, 1, 7'd20);
    check("R6 guard true writes", {31'd0, res_wen}, 32'd1);
    check("R6 guard true data", res_data, 32'h7fff7fff);
    issue_one(0, 32'h00050005, 0, 0, 7'd21);
    check("R7 unguarded lsb0 writes", {31'd0, res_wen}, 32'd1);
  endtask

  task automatic t_latency();
    iss_valid = 1; iss_src_b = 32'h0001fffe; iss_tag = 7'd33;
    step(); idle();
    check("R5 not after one edge", {31'd0, res_wen}, 32'd0);
    step();
    check("R5 after two edges", {31'd0, res_wen}, 32'd1);
    check("R5 data", res_data, 32'h00010002);
    step();
    check("R5 single result", {31'd0, res_wen}, 32'd0);
  endtask

  task automatic t_stream();
    logic [31:0] srcs [12];
    logic        gds  [12];
    logic        gls  [12];
    for (int i = 0; i < 12; i++) begin
      srcs[i] = {16'h8000 + 16'(i * 4099), 16'h7ff0 + 16'(i * 8191)};
      gds[i]  = (i % 3) != 0;
      gls[i]  = (i % 4) != 1;
    end
    for (int i = 0; i < 14; i++) begin
      if (i < 12) begin
        iss_valid = 1; iss_src_a = 0; iss_src_b = srcs[i];
        iss_guarded = gds[i]; iss_guard_lsb = gls[i]; iss_tag = 7'(40 + i);
      end else idle();
      step();
      if (i >= 1 && i <= 12) begin
        // result of issue i-1 visible now
        check("R8 stream wen", {31'd0, res_wen},
              {31'd0, (!gds[i-1] || gls[i-1])});
        check("R8 stream data", res_data, word_ref(srcs[i-1]));
        check("R8 stream tag", {25'd0, res_tag}, 32'(40 + i - 1));
        check("R3 sign bits clear", {30'd0, res_data[31], res_data[15]}, 32'd0);
      end
    end
    idle();
  endtask

  task automatic t_flag();
    issue_one(32'h00000100, 32'hfff00010, 0, 0, 7'd3);
    check("R10 flag set", {31'd0, res_a_nonzero}, 32'd1);
    check("R10 data unaffected", res_data, 32'h00100010);
    issue_one(0, 32'hfff00010, 0, 0, 7'd3);
    check("R10 flag clear", {31'd0, res_a_nonzero}, 32'd0);
  endtask

  task automatic t_midreset();
    iss_valid = 1; iss_src_b = 32'h12345678; iss_tag = 7'd9;
    step(); idle();
    rst = 1;
    step();
    check("R9 in-flight dropped", {31'd0, res_wen}, 32'd0);
    rst = 0;
    step();
    check("R9 nothing after reset", {31'd0, res_wen}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_examples();
    t_guard();
    t_latency();
    t_stream();
    t_flag();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule